// File: doc/BRIEF.md
# Five-Level Hybrid Leg Modulator

This block turns a signed digital reference into switch gate commands for one leg of a five-level inverter. The leg is built from two stacked three-level flying-capacitor cells that share a clamped neutral point. The block runs a phase counter that produces triangular carriers. The sign of the reference picks which stack is active. The active stack compares the reference magnitude against two carriers that are half a carrier period apart. Each stack therefore has two cells, and the two ways of turning on exactly one cell are the redundant states that keep its flying capacitor balanced. The resting stack is held with its upper gates off and its lower gates on.

The reference is captured twice per carrier period and held between captures. A mode input shifts the negative-stack carriers by a quarter period for three-phase operation. Every cell drives a complementary gate pair through a dead-time stage. Outside logic supplies the reference and the period and dead-time settings, and uses the level and half-cycle outputs to supervise the leg.

Top module: `hyb5_leg_mod`

## Requirements
- R1: `levelOut` is a 3-bit two's-complement level in the range -2..+2. It equals the number of active-stack cells that are on, with the sign of the active stack. It is registered one clock after the phase and held sample it is computed from.
- R2: With both positive cells commanded on, the gates settle to `gateHi`=4'b0011 and `gateLo`=4'b1100. Bits 0 and 1 are positive-stack cells A and B; bits 2 and 3 are negative-stack cells A and B.
- R3: The reference is captured when the phase counter equals 0 or equals the effective peak P, and is held unchanged between those points.
- R4: A held reference of zero or above selects the positive stack and sets `posHalf`=1. A negative held reference selects the negative stack, sets `posHalf`=0, and gives the mirrored negative level.
- R5: The cells of the resting stack are commanded off, so its gates sit at hi=0 and lo=1.
- R6: The phase runs 0..2P-1 and wraps, where P is `periodCfg` (values below 2 act as 2). Triangle tri(x) is x for x<P and 2P-x otherwise. Cell A of a stack uses tri(phase+offset) and cell B uses tri(phase+offset+P). A cell is on when the magnitude exceeds its carrier.
- R7: With `threePhase`=1, the negative-stack offset is floor(P/2). With `threePhase`=0, both stacks use offset 0.
- R8: A magnitude of P or more turns both cells of the active stack on, for every phase.
- R9: The hi and lo gates of a pair are never on together. A gate turns on `deadCfg`+1 cycles after its complement turns off.
- R10: While `rst` is high (synchronous), the phase restarts at 0, the held reference is 0, `levelOut`=0, `posHalf`=1, and all gates sit at hi=0, lo=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| refIn | input | REF_W | Signed reference sample |
| periodCfg | input | CNT_W | Carrier peak P |
| deadCfg | input | DT_W | Dead time in cycles, minus one |
| threePhase | input | 1 | Quarter-period shift of negative-stack carriers |
| gateHi | output | 4 | Upper gate of each cell pair |
| gateLo | output | 4 | Lower gate of each cell pair |
| levelOut | output | 3 | Signed output level |
| posHalf | output | 1 | Positive stack active |

## Verification
`levelOut` and `posHalf` are due one clock after the phase and held sample they come from. The held sample itself changes one clock after a capture point. The bench therefore keeps its own phase and held value, updated on the same edge, and compares both outputs at every falling edge against the carrier equations. Gate timing is measured separately: the bench counts falling edges from a lower-gate drop to the matching upper-gate rise, and expects `deadCfg`+1. Settled gate states are read only after that window has passed.

// File: rtl/hyb5_pkg.sv
package hyb5_pkg;
  typedef struct packed {
    logic atZero;
    logic atPeak;
  } ctrlStb_t;
  localparam int NUM_CELLS = 4;
endpackage

// File: rtl/hyb5_ctrl.sv
module hyb5_ctrl
  import hyb5_pkg::*;
#(
  parameter int CNT_W = 10,
  localparam int PH_W = CNT_W + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [CNT_W-1:0]          periodCfg,
  input  logic                      threePhase,
  output ctrlStb_t                  stb,
  output logic [PH_W-1:0]           effPeak,
  output logic [3:0][PH_W-1:0]      carr
);
  logic [PH_W-1:0] phase, twoP, quarter;
  logic [PH_W-1:0] offs [4];

  function automatic logic [PH_W-1:0] triOf(input logic [PH_W-1:0] x,
                                            input logic [PH_W-1:0] p);
    return (x < p) ? x : PH_W'((p << 1) - x);
  endfunction

  function automatic logic [PH_W-1:0] wrapAdd(input logic [PH_W-1:0] x,
                                              input logic [PH_W-1:0] off,
                                              input logic [PH_W-1:0] p2);
    logic [PH_W:0] s;
    s = {1'b0, x} + {1'b0, off};
    if (s >= {1'b0, p2}) s = s - {1'b0, p2};
    return s[PH_W-1:0];
  endfunction

  assign effPeak = (periodCfg < CNT_W'(2)) ? PH_W'(2) : PH_W'(periodCfg);
  assign twoP    = PH_W'(effPeak << 1);
  assign quarter = threePhase ? (effPeak >> 1) : '0;

  assign offs[0] = '0;
  assign offs[1] = effPeak;
  assign offs[2] = quarter;
  assign offs[3] = PH_W'(quarter + effPeak);

  always_ff @(posedge clk) begin
    if (rst)                      phase <= '0;
    else if (phase >= twoP - 1'b1) phase <= '0;
    else                          phase <= phase + 1'b1;
  end

  for (genvar k = 0; k < NUM_CELLS; k++) begin : g_carr
    assign carr[k] = triOf(wrapAdd(phase, offs[k], twoP), effPeak);
  end

  assign stb.atZero = (phase == '0);
  assign stb.atPeak = (phase == effPeak);

  assert_phase_step_R6: assert property (@(posedge clk) disable iff (rst)
    (phase == '0) || (phase == $past(phase) + 1'b1));
endmodule

// File: rtl/hyb5_datapath.sv
module hyb5_datapath
  import hyb5_pkg::*;
#(
  parameter int REF_W = 12,
  parameter int CNT_W = 10,
  localparam int PH_W  = CNT_W + 1,
  localparam int CMP_W = ((REF_W > PH_W) ? REF_W : PH_W) + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  ctrlStb_t                  stb,
  input  logic signed [REF_W-1:0]   refIn,
  input  logic [PH_W-1:0]           effPeak,
  input  logic [3:0][PH_W-1:0]      carr,
  output logic [NUM_CELLS-1:0]      cellCmd,
  output logic signed [2:0]         levelOut,
  output logic                      posHalf
);
  logic signed [REF_W-1:0] refHeld;
  logic [REF_W-1:0]        mag;
  logic                    posSel, sat;
  logic [1:0]              cellOn;
  logic [1:0]              onCount;
  logic signed [2:0]       levelNext;
  logic [NUM_CELLS-1:0]    cmdNext;

  always_ff @(posedge clk) begin
    if (rst)                            refHeld <= '0;
    else if (stb.atZero || stb.atPeak)  refHeld <= refIn;
  end

  assign posSel = ~refHeld[REF_W-1];
  assign mag    = posSel ? refHeld : REF_W'(-refHeld);
  assign sat    = CMP_W'(mag) >= CMP_W'(effPeak);

  for (genvar k = 0; k < 2; k++) begin : g_cell
    logic [PH_W-1:0] selCarr;
    assign selCarr   = posSel ? carr[k] : carr[k+2];
    assign cellOn[k] = sat || (CMP_W'(mag) > CMP_W'(selCarr));
  end

  assign onCount   = {1'b0, cellOn[0]} + {1'b0, cellOn[1]};
  assign levelNext = posSel ? $signed({1'b0, onCount}) : -$signed({1'b0, onCount});
  assign cmdNext   = posSel ? {2'b00, cellOn} : {cellOn, 2'b00};

  always_ff @(posedge clk) begin
    if (rst) begin
      cellCmd  <= '0;
      levelOut <= '0;
      posHalf  <= 1'b1;
    end else begin
      cellCmd  <= cmdNext;
      levelOut <= levelNext;
      posHalf  <= posSel;
    end
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(stb.atZero || stb.atPeak) |-> $stable(refHeld));
endmodule

// File: rtl/hyb5_deadtime.sv
module hyb5_deadtime #(
  parameter int DT_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmdOn,
  input  logic [DT_W-1:0] deadCfg,
  output logic            hiG,
  output logic            loG
);
  logic            curOn;
  logic [DT_W-1:0] timer;

  always_ff @(posedge clk) begin
    if (rst) begin
      curOn <= 1'b0;
      timer <= '0;
      hiG   <= 1'b0;
      loG   <= 1'b1;
    end else if (cmdOn != curOn) begin
      curOn <= cmdOn;
      timer <= deadCfg;
      hiG   <= 1'b0;
      loG   <= 1'b0;
    end else if (timer != '0) begin
      timer <= timer - 1'b1;
    end else begin
      hiG <= curOn;
      loG <= ~curOn;
    end
  end

  assert_pair_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(hiG && loG));
  assert_hi_gap_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(hiG) |-> !$past(loG));
  assert_lo_gap_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(loG) |-> !$past(hiG));
endmodule

// File: rtl/hyb5_leg_mod.sv
module hyb5_leg_mod
  import hyb5_pkg::*;
#(
  parameter int REF_W = 12,
  parameter int CNT_W = 10,
  parameter int DT_W  = 6,
  localparam int PH_W = CNT_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [REF_W-1:0] refIn,
  input  logic [CNT_W-1:0]        periodCfg,
  input  logic [DT_W-1:0]         deadCfg,
  input  logic                    threePhase,
  output logic [3:0]              gateHi,
  output logic [3:0]              gateLo,
  output logic signed [2:0]       levelOut,
  output logic                    posHalf
);
  ctrlStb_t                 stb;
  logic [PH_W-1:0]          effPeak;
  logic [3:0][PH_W-1:0]     carr;
  logic [NUM_CELLS-1:0]     cellCmd;

  hyb5_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rst(rst), .periodCfg(periodCfg), .threePhase(threePhase),
    .stb(stb), .effPeak(effPeak), .carr(carr)
  );

  hyb5_datapath #(.REF_W(REF_W), .CNT_W(CNT_W)) i_dp (
    .clk(clk), .rst(rst), .stb(stb), .refIn(refIn), .effPeak(effPeak),
    .carr(carr), .cellCmd(cellCmd), .levelOut(levelOut), .posHalf(posHalf)
  );

  for (genvar k = 0; k < NUM_CELLS; k++) begin : g_dt
    hyb5_deadtime #(.DT_W(DT_W)) i_dt (
      .clk(clk), .rst(rst), .cmdOn(cellCmd[k]), .deadCfg(deadCfg),
      .hiG(gateHi[k]), .loG(gateLo[k])
    );
  end

  assert_reset_state_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (levelOut == 3'sd0 && posHalf && gateHi == 4'h0 && gateLo == 4'hF));
endmodule

// File: tb/test_hyb5_leg_mod.sv
module test_hyb5_leg_mod;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [11:0] refIn = '0;
  logic [9:0] periodCfg = 10'd8;
  logic [5:0] deadCfg = 6'd2;
  logic threePhase = 1'b0;
  logic [3:0] gateHi, gateLo;
  logic signed [2:0] levelOut;
  logic posHalf;

  int errs = 0;
  int checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  hyb5_leg_mod i_hyb5_leg_mod (
    .clk(clk), .rst(rst), .refIn(refIn), .periodCfg(periodCfg),
    .deadCfg(deadCfg), .threePhase(threePhase), .gateHi(gateHi),
    .gateLo(gateLo), .levelOut(levelOut), .posHalf(posHalf)
  );

  // Expected-value model built from the carrier and sampling requirements
  int bPh, bHeld, bLvl;
  bit bPos;

  function automatic int triB(int x, int p);
    return (x < p) ? x : 2 * p - x;
  endfunction

  function automatic int peakOf();
    return (periodCfg < 2) ? 2 : int'(periodCfg);
  endfunction

  function automatic int modelLevel(int ph, int held, bit three, int p);
    int m, q, ca, cb, n;
    m = (held < 0) ? -held : held;
    q = three ? p / 2 : 0;
    if (held >= 0) begin
      ca = triB(ph % (2 * p), p);
      cb = triB((ph + p) % (2 * p), p);
    end else begin
      ca = triB((ph + q) % (2 * p), p);
      cb = triB((ph + q + p) % (2 * p), p);
    end
    n = ((m >= p) || (m > ca) ? 1 : 0) + ((m >= p) || (m > cb) ? 1 : 0);
    return (held >= 0) ? n : -n;
  endfunction

  always @(posedge clk) begin
    int p;
    p = peakOf();
    if (rst) begin
      bPh <= 0; bHeld <= 0; bLvl <= 0; bPos <= 1'b1;
    end else begin
      bLvl <= modelLevel(bPh, bHeld, threePhase, p);
      bPos <= (bHeld >= 0);
      if (bPh == 0 || bPh == p) bHeld <= int'(refIn);
      bPh <= (bPh >= 2 * p - 1) ? 0 : bPh + 1;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic restart(int p, int d, bit three, int r);
    @(negedge clk);
    rst = 1'b1;
    periodCfg = 10'(p); deadCfg = 6'(d); threePhase = three; refIn = 12'(r);
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic compareRun(string req, int n, bit restCheck);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(int'(levelOut) == bLvl, {req, " level"}, int'(levelOut), bLvl);
      check(posHalf == bPos, {req, " posHalf"}, posHalf, bPos);
      check((gateHi & gateLo) == 4'h0, "R9 exclusive pair", gateHi & gateLo, 0);
      if (restCheck)
        check(gateHi[3:2] == 2'b00 && gateLo[3:2] == 2'b11, "R5 resting stack",
              {gateHi[3:2], gateLo[3:2]}, 4'b0011);
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    rst = 1'b1; refIn = 12'sd5;
    repeat (2) @(negedge clk);
    check(levelOut == 3'sd0, "R10 level in reset", int'(levelOut), 0);
    check(posHalf == 1'b1, "R10 posHalf in reset", posHalf, 1);
    check(gateHi == 4'h0 && gateLo == 4'hF, "R10 gates in reset", {gateHi, gateLo}, 8'h0F);
    rst = 1'b0;
  endtask

  task automatic testPositiveLow();   // R1 R6 R5: level 0/+1 only
    restart(8, 1, 1'b0, 3);
    compareRun("R1 R6 positive small", 48, 1'b1);
  endtask

  task automatic testPositiveHigh();  // R1: reaches +2
    restart(8, 1, 1'b0, 6);
    compareRun("R1 positive large", 48, 1'b1);
  endtask

  task automatic testNegative();      // R4 mirror
    restart(8, 1, 1'b0, -5);
    compareRun("R4 negative", 48, 1'b0);
  endtask

  task automatic testThreePhase();    // R7 quarter shift on negative stack
    restart(8, 1, 1'b1, -3);
    compareRun("R7 three-phase negative", 48, 1'b0);
    restart(10, 1, 1'b1, 4);
    compareRun("R7 three-phase positive", 40, 1'b1);
  endtask

  task automatic testSaturation();    // R8, R2
    restart(8, 2, 1'b0, 100);
    compareRun("R8 saturate positive", 24, 1'b1);
    check(levelOut == 3'sd2, "R8 level +2", int'(levelOut), 2);
    check(gateHi == 4'b0011 && gateLo == 4'b1100, "R2 gates at +2",
          {gateHi, gateLo}, 8'b0011_1100);
    restart(8, 2, 1'b0, -2048);
    compareRun("R8 saturate most negative", 24, 1'b0);
    check(levelOut == -3'sd2, "R8 level -2", int'(levelOut), -2);
  endtask

  task automatic testSampling();      // R3 hold between capture points
    restart(8, 1, 1'b0, 2);
    for (int i = 0; i < 60; i++) begin
      refIn = 12'(((i * 7) % 19) - 9);
      compareRun("R3 sample and hold", 1, 1'b0);
    end
  endtask

  task automatic measureDead(int d);
    int n;
    restart(40, d, 1'b0, 10);
    n = 0;
    while (gateLo[0] == 1'b1 && n < 400) begin @(negedge clk); n++; end
    n = 0;
    while (gateHi[0] == 1'b0 && n < 400) begin @(negedge clk); n++; end
    check(n == d + 1, "R9 dead-time gap", n, d + 1);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testPositiveLow();
    testPositiveHigh();
    testNegative();
    testThreePhase();
    testSaturation();
    testSampling();
    measureDead(5);
    measureDead(0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule